// File: doc/BRIEF.md
# CompactFlash Sector Read Sequencer

This block is a hardware master that reads 512-byte sectors through a CompactFlash management controller. It sits on the controller's 16-bit register bus and takes the place of a software read loop. A request gives a starting logical block address and a sector count. The block then claims the controller's lock and checks that a card is present and that the controller will take a command. It splits the request into chunks and programs the address and command for each one. It brackets each chunk's transfer with a configuration-reset pulse and drains the sector buffer in bursts. The sector contents come out as a byte stream with valid/ready flow control.

A request finishes with a single-cycle done pulse that carries a 2-bit outcome: 0 for success, 1 for lock timeout, 2 for no card and 3 for controller not ready. The lock is handed back on every outcome. Bus reads return data in the cycle after the read strobe. Writes complete in the cycle of the strobe.

Top module: `cf_sector_reader`

## Requirements
- R1: After reset the block makes exactly one write to address 0x00, before it first raises req_ready. The value is 0x0001 when BUS16 is 1 and 0x0000 otherwise.
- R2: To take the lock, the block reads address 0x18 and writes the value back with bit 1 set. It then reads status (0x04) until status bit 1 is set. If LOCK_POLLS status reads all show the bit clear, it stops polling and finishes with outcome 1.
- R3: During the readiness check, a status read with bit 4 (card present) clear ends the request with outcome 2, and no command is written.
- R4: If READY_POLLS status reads in a row show bit 8 (ready for command) clear while a card is present, the request ends with outcome 3.
- R5: A request is split into chunks of min(remaining, MAX_CHUNK) sectors. Each chunk writes LBA[15:0] to 0x10, then LBA[27:16] zero-extended to 0x12, then 0x0300 | (chunk mod 256) to 0x14. The LBA advances by the chunk size after each chunk.
- R6: After each command write, bit 7 of 0x18 is set by read-modify-write and is cleared the same way once the chunk is drained. Every data-register read happens while bit 7 and bit 1 are set.
- R7: Each burst waits for a status read with bit 5 (buffer ready) set and then reads 16 words from 0x40. A sector takes 16 bursts, so a request of N sectors reads 256·N words.
- R8: Each data word is put on the stream as its low byte followed by its high byte.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R10: On every outcome the block ends by clearing bit 1 of 0x18 through read-modify-write. It leaves bit 7 clear.
- R11: done is a one-cycle pulse with done_status valid in the same cycle. req_ready is high only when the block is idle, and no stream byte or done is produced while idle.
- R12: A request with count 0 finishes with outcome 0 and makes no bus access.
- R13: bus_rd and bus_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_lba | input | LBA_W | First sector address |
| req_count | input | CNT_W | Number of sectors |
| bus_addr | output | ADDR_W | Register byte address |
| bus_wdata | output | 16 | Write data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rdata | input | 16 | Read data, valid the cycle after bus_rd |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 8 | Stream byte |
| done | output | 1 | Request finished pulse |
| done_status | output | 2 | Outcome: 0 ok, 1 lock, 2 no card, 3 not ready |

## Verification
The checker watches the following on every cycle:
- the read and write strobes never overlap;
- a stalled stream byte stays valid and unchanged;
- done lasts one cycle;
- the idle state is quiet;
- every command and upper-address write has the right shape.

Other behaviours only the scenarios can show, because they need a model of the controller: the order of lock, readiness and reset steps, the poll counts before each timeout, chunk splitting across a 16-bit address boundary, the byte order of the drained words, and release of the lock after each kind of failure.

// File: rtl/cf_sector_reader.sv
module cf_sector_reader #(
  parameter bit BUS16       = 1'b1,
  parameter int ADDR_W      = 7,
  parameter int LBA_W       = 28,
  parameter int CNT_W       = 16,
  parameter int MAX_CHUNK   = 256,
  parameter int LOCK_POLLS  = 64,
  parameter int READY_POLLS = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LBA_W-1:0]  req_lba,
  input  logic [CNT_W-1:0]  req_count,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [15:0]       bus_wdata,
  output logic              bus_rd,
  output logic              bus_wr,
  input  logic [15:0]       bus_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              done,
  output logic [1:0]        done_status
);
  localparam int CH_W  = $clog2(MAX_CHUNK + 1);
  localparam int BST_W = CH_W + 4;
  localparam int PMAX  = (LOCK_POLLS > READY_POLLS) ? LOCK_POLLS : READY_POLLS;
  localparam int PC_W  = $clog2(PMAX + 1);

  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_LBLO = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_LBHI = ADDR_W'(8'h12);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(8'h40);

  typedef enum logic [4:0] {
    S_MODE, S_IDLE, S_LK_RD, S_LK_WR, S_LK_POLL, S_LK_CHK, S_RY_POLL, S_RY_CHK,
    S_LBA_LO, S_LBA_HI, S_CMD, S_RS_RD, S_RS_WR, S_BF_POLL, S_BF_CHK, S_DT_RD,
    S_DT_CAP, S_LO, S_HI, S_CL_RD, S_CL_WR, S_RL_RD, S_RL_WR, S_DONE
  } state_t;

  state_t           st;
  logic [LBA_W-1:0] lba;
  logic [CNT_W-1:0] rem;
  logic [PC_W-1:0]  polls;
  logic [3:0]       wcnt;
  logic [BST_W-1:0] bcnt;
  logic [15:0]      word;
  logic [1:0]       stat;
  logic [CH_W-1:0]  chunk;
  logic             last_burst;

  assign chunk      = (rem > CNT_W'(MAX_CHUNK)) ? CH_W'(MAX_CHUNK) : CH_W'(rem);
  assign last_burst = (bcnt == ({chunk, 4'b0000} - BST_W'(1)));

  assign req_ready   = (st == S_IDLE);
  assign out_valid   = (st == S_LO) || (st == S_HI);
  assign out_data    = (st == S_HI) ? word[15:8] : word[7:0];
  assign done        = (st == S_DONE);
  assign done_status = stat;

  always_comb begin
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = A_MODE;
    bus_wdata = 16'h0000;
    case (st)
      S_MODE:   begin bus_wr = 1'b1; bus_wdata = BUS16 ? 16'h0001 : 16'h0000; end
      S_LK_RD, S_RS_RD, S_CL_RD, S_RL_RD: begin bus_rd = 1'b1; bus_addr = A_CTRL; end
      S_LK_WR:  begin bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = bus_rdata | 16'h0002; end
      S_RS_WR:  begin bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = bus_rdata | 16'h0080; end
      S_CL_WR:  begin bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = bus_rdata & ~16'h0080; end
      S_RL_WR:  begin bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = bus_rdata & ~16'h0002; end
      S_LK_POLL, S_RY_POLL, S_BF_POLL: begin bus_rd = 1'b1; bus_addr = A_STAT; end
      S_LBA_LO: begin bus_wr = 1'b1; bus_addr = A_LBLO; bus_wdata = 16'(lba); end
      S_LBA_HI: begin bus_wr = 1'b1; bus_addr = A_LBHI; bus_wdata = 16'(lba >> 16) & 16'h0FFF; end
      S_CMD:    begin bus_wr = 1'b1; bus_addr = A_CMD;  bus_wdata = {8'h03, 8'(chunk)}; end
      S_DT_RD:  begin bus_rd = 1'b1; bus_addr = A_DATA; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_MODE;
      lba   <= '0;
      rem   <= '0;
      polls <= '0;
      wcnt  <= '0;
      bcnt  <= '0;
      word  <= '0;
      stat  <= 2'd0;
    end else begin
      case (st)
        S_MODE: st <= S_IDLE;
        S_IDLE: if (req_valid) begin
          lba  <= req_lba;
          rem  <= req_count;
          stat <= 2'd0;
          st   <= (req_count == '0) ? S_DONE : S_LK_RD;
        end
        S_LK_RD: st <= S_LK_WR;
        S_LK_WR: begin polls <= '0; st <= S_LK_POLL; end
        S_LK_POLL: st <= S_LK_CHK;
        S_LK_CHK:
          if (bus_rdata[1]) begin
            polls <= '0;
            st    <= S_RY_POLL;
          end else if (polls == PC_W'(LOCK_POLLS - 1)) begin
            stat <= 2'd1;
            st   <= S_RL_RD;
          end else begin
            polls <= polls + 1'b1;
            st    <= S_LK_POLL;
          end
        S_RY_POLL: st <= S_RY_CHK;
        S_RY_CHK:
          if (!bus_rdata[4]) begin
            stat <= 2'd2;
            st   <= S_RL_RD;
          end else if (bus_rdata[8]) begin
            st <= S_LBA_LO;
          end else if (polls == PC_W'(READY_POLLS - 1)) begin
            stat <= 2'd3;
            st   <= S_RL_RD;
          end else begin
            polls <= polls + 1'b1;
            st    <= S_RY_POLL;
          end
        S_LBA_LO: st <= S_LBA_HI;
        S_LBA_HI: st <= S_CMD;
        S_CMD: begin
          wcnt <= '0;
          bcnt <= '0;
          st   <= S_RS_RD;
        end
        S_RS_RD: st <= S_RS_WR;
        S_RS_WR: st <= S_BF_POLL;
        S_BF_POLL: st <= S_BF_CHK;
        S_BF_CHK: st <= bus_rdata[5] ? S_DT_RD : S_BF_POLL;
        S_DT_RD: st <= S_DT_CAP;
        S_DT_CAP: begin word <= bus_rdata; st <= S_LO; end
        S_LO: if (out_ready) st <= S_HI;
        S_HI: if (out_ready) begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == 4'd15) begin
            bcnt <= bcnt + 1'b1;
            st   <= last_burst ? S_CL_RD : S_BF_POLL;
          end else begin
            st <= S_DT_RD;
          end
        end
        S_CL_RD: st <= S_CL_WR;
        S_CL_WR: begin
          lba <= lba + LBA_W'(chunk);
          rem <= rem - CNT_W'(chunk);
          st  <= (rem == CNT_W'(chunk)) ? S_RL_RD : S_LBA_LO;
        end
        S_RL_RD: st <= S_RL_WR;
        S_RL_WR: st <= S_DONE;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cf_sector_reader_chk.sv
module cf_sector_reader_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              done
);
  p_one_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!out_valid && !done));

  p_cmd_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(8'h14)) |-> (bus_wdata[15:8] == 8'h03));

  p_lba_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(8'h12)) |-> (bus_wdata[15:12] == 4'h0));
endmodule

bind cf_sector_reader cf_sector_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .done(done)
);

// File: tb/test_cf_sector_reader.sv
module test_cf_sector_reader;
  localparam int MAXC = 4;
  localparam int LKP  = 6;
  localparam int RYP  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [27:0] req_lba = '0;
  logic [15:0] req_count = '0;
  logic [6:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_rdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        done;
  logic [1:0]  done_status;

  always #2 clk = ~clk;

  cf_sector_reader #(.BUS16(1'b1), .MAX_CHUNK(MAXC), .LOCK_POLLS(LKP), .READY_POLLS(RYP)) i_cf_sector_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lba(req_lba), .req_count(req_count), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .done(done), .done_status(done_status)
  );

  int checks = 0;
  int fails = 0;

  // controller model
  logic [15:0] ctrl_reg = '0;
  bit grant_en = 1'b1, card = 1'b1, rdy = 1'b1, bp_mode = 1'b0;
  int st_reads = 0, dcnt = 0, rst_viol = 0, acc_n = 0, both_n = 0;
  int mode_wr = 0, wr_n = 0;
  logic [15:0] mode_val = '0;
  logic [6:0]  wlog_a [0:63];
  logic [15:0] wlog_d [0:63];
  int rx_n = 0, rx_bad = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (bus_rd && bus_wr) both_n++;
      if (bus_rd) begin
        acc_n++;
        case (bus_addr)
          7'h18: bus_rdata <= ctrl_reg;
          7'h04: begin
            bus_rdata <= {7'b0, rdy, 2'b0, st_reads[0], card, 2'b0, ctrl_reg[1] & grant_en, 1'b0};
            st_reads++;
          end
          7'h40: begin
            bus_rdata <= dcnt[15:0];
            dcnt++;
            if (!ctrl_reg[7] || !ctrl_reg[1]) rst_viol++;
          end
          default: bus_rdata <= 16'hDEAD;
        endcase
      end
      if (bus_wr) begin
        acc_n++;
        wlog_a[wr_n % 64] <= bus_addr;
        wlog_d[wr_n % 64] <= bus_wdata;
        wr_n++;
        if (bus_addr == 7'h18) ctrl_reg <= bus_wdata;
        if (bus_addr == 7'h00) begin mode_wr++; mode_val <= bus_wdata; end
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      logic [15:0] w;
      logic [7:0] e;
      w = 16'(rx_n >> 1);
      e = rx_n[0] ? w[15:8] : w[7:0];
      if (out_data !== e) rx_bad++;
      rx_n++;
    end
  end

  always @(negedge clk) out_ready <= bp_mode ? ((cyc % 3) != 0) : 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [27:0] lba, input logic [15:0] cnt, output logic [1:0] stv);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_lba = lba; req_count = cnt; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    stv = 2'bxx;
    for (int i = 0; i < 60000; i++) begin
      if (done) begin stv = done_status; break; end
      @(negedge clk);
    end
  endtask

  task automatic check_chunks(input int from, input logic [27:0] lba0, input int cnt, input string tag);
    int rem = cnt;
    int l = int'(lba0);
    int nch = 0;
    int expch = (cnt + MAXC - 1) / MAXC;
    for (int i = from; i < wr_n; i++) begin
      int ch = (rem > MAXC) ? MAXC : rem;
      logic [6:0] a = wlog_a[i % 64];
      int d = int'(wlog_d[i % 64]);
      if (a == 7'h10) check(d == (l & 16'hFFFF), {tag, " lba lo"}, d, l & 16'hFFFF);
      if (a == 7'h12) check(d == ((l >> 16) & 16'h0FFF), {tag, " lba hi"}, d, (l >> 16) & 16'h0FFF);
      if (a == 7'h14) begin
        check(d == (16'h0300 | (ch & 8'hFF)), {tag, " cmd word"}, d, 16'h0300 | (ch & 8'hFF));
        l += ch; rem -= ch; nch++;
      end
    end
    check(nch == expch, {tag, " chunk count"}, nch, expch);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(mode_wr == 1, "R1 mode write count", mode_wr, 1);
    check(mode_val == 16'h0001, "R1 mode value", mode_val, 16'h0001);
    check(req_ready == 1'b1, "R11 idle ready", req_ready, 1);
    check(done == 1'b0 && out_valid == 1'b0, "R11 idle quiet", {done, out_valid}, 0);
  endtask

  task automatic t_basic;
    logic [1:0] s;
    int w0 = wr_n, r0 = rx_n, b0 = rx_bad, d0 = dcnt;
    run_req(28'hABCDEF1, 16'd3, s);
    check(s == 2'd0, "R11 ok status", s, 0);
    check_chunks(w0, 28'hABCDEF1, 3, "R5 single");
    check(dcnt - d0 == 3 * 256, "R7 words read", dcnt - d0, 3 * 256);
    check(rx_n - r0 == 3 * 512, "R8 bytes out", rx_n - r0, 3 * 512);
    check(rx_bad == b0, "R8 byte order", rx_bad - b0, 0);
    check(rst_viol == 0, "R6 reset bit during reads", rst_viol, 0);
    check(ctrl_reg[1] == 1'b0 && ctrl_reg[7] == 1'b0, "R10 control after ok", ctrl_reg, 0);
    check(both_n == 0, "R13 strobe overlap", both_n, 0);
    @(negedge clk);
    check(done == 1'b0, "R11 done pulse", done, 0);
  endtask

  task automatic t_split;
    logic [1:0] s;
    int w0 = wr_n, b0 = rx_bad, d0 = dcnt;
    run_req(28'h000FFFE, 16'd10, s);
    check(s == 2'd0, "R5 split status", s, 0);
    check_chunks(w0, 28'h000FFFE, 10, "R5 split");
    check(dcnt - d0 == 10 * 256, "R7 split words", dcnt - d0, 10 * 256);
    check(rx_bad == b0, "R8 split bytes", rx_bad - b0, 0);
    check(rst_viol == 0, "R6 split reset bit", rst_viol, 0);
  endtask

  task automatic t_bp;
    logic [1:0] s;
    int r0 = rx_n, b0 = rx_bad;
    bp_mode = 1'b1;
    run_req(28'h0000020, 16'd1, s);
    bp_mode = 1'b0;
    check(s == 2'd0, "R9 status", s, 0);
    check(rx_n - r0 == 512, "R9 byte count", rx_n - r0, 512);
    check(rx_bad == b0, "R9 bytes intact", rx_bad - b0, 0);
  endtask

  task automatic t_nocard;
    logic [1:0] s;
    int w0 = wr_n, n14 = 0;
    card = 1'b0;
    run_req(28'h0000100, 16'd2, s);
    card = 1'b1;
    check(s == 2'd2, "R3 status", s, 2);
    for (int i = w0; i < wr_n; i++) if (wlog_a[i % 64] == 7'h14) n14++;
    check(n14 == 0, "R3 no command", n14, 0);
    check(ctrl_reg[1] == 1'b0, "R10 release after no card", ctrl_reg[1], 0);
  endtask

  task automatic t_notready;
    logic [1:0] s;
    int p0 = st_reads;
    rdy = 1'b0;
    run_req(28'h0000200, 16'd2, s);
    rdy = 1'b1;
    check(s == 2'd3, "R4 status", s, 3);
    check(st_reads - p0 == 1 + RYP, "R4 poll count", st_reads - p0, 1 + RYP);
    check(ctrl_reg[1] == 1'b0, "R10 release after not ready", ctrl_reg[1], 0);
  endtask

  task automatic t_lock;
    logic [1:0] s;
    int p0 = st_reads;
    grant_en = 1'b0;
    run_req(28'h0000300, 16'd1, s);
    grant_en = 1'b1;
    check(s == 2'd1, "R2 status", s, 1);
    check(st_reads - p0 == LKP, "R2 poll count", st_reads - p0, LKP);
    check(ctrl_reg[1] == 1'b0, "R10 release after lock timeout", ctrl_reg[1], 0);
  endtask

  task automatic t_zero;
    logic [1:0] s;
    int a0 = acc_n;
    run_req(28'h0000400, 16'd0, s);
    check(s == 2'd0, "R12 status", s, 0);
    check(acc_n == a0, "R12 no bus access", acc_n - a0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_split();
    t_bp();
    t_nocard();
    t_notready();
    t_lock();
    t_zero();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule